// File: doc/BRIEF.md
# I2C Master Interrupt and Status Gating

This block sits between the byte engine of an I2C master and the register bus that software uses. The engine raises one-cycle pulses when a bus event happens: a START was placed on the bus, the address byte went out, a byte finished, the receive holding register filled, the transmit holding register emptied, a bus error occurred, arbitration was lost, or the slave did not acknowledge. Each pulse sets a sticky flag. The flags are shown together in status register 1 and are combined with three enable bits into two level-sensitive interrupt lines: one for bus events and one for errors.

Software clears the flags in several ways. An error flag is cleared by writing a zero to its bit in status register 1. The address-sent flag clears when status register 1 is read and status register 2 is read after it. The start-sent flag clears when status register 1 is read and the data register is written after it. The holding-register flags clear when the data register is accessed. Transmit-empty and receive-not-empty are buffer events. They reach the event line only when the buffer enable and the event enable are both set. This lets software take the address and byte-finished phases without an interrupt for every byte.

The register bus uses a 2-bit select: 0 is the control register, 1 is status register 1, 2 is status register 2 and 3 is the data register. A read or write strobe lasts one cycle. `rd_data` is combinational from the select and the current state. The contents of status register 2 and of the data register belong to other blocks, so `rd_data` returns zero for selects 2 and 3.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, all flags, all enables and the frequency field are zero, and `irq_evt` and `irq_err` are low.
- R2: Select 0 reads and writes the control register. Bits 5:0 hold the input clock frequency in MHz, bit 8 is the error enable, bit 9 is the event enable and bit 10 is the buffer enable. All other bits read as zero.
- R3: Select 1 reads status register 1: start-sent at bit 0, address-sent at bit 1, byte-finished at bit 2, receive-not-empty at bit 6, transmit-empty at bit 7, bus error at bit 8, arbitration lost at bit 9, acknowledge failure at bit 10. All other bits read as zero. Selects 2 and 3 read as zero.
- R4: A set pulse makes its flag read 1 from the next clock edge. A set pulse wins over a clear of the same flag in the same cycle.
- R5: `irq_evt` is high while the event enable is set and any of start-sent, address-sent or byte-finished is set.
- R6: Transmit-empty and receive-not-empty drive `irq_evt` only while both the event enable and the buffer enable are set. A masked flag stays set.
- R7: `irq_err` is high while the error enable is set and any of bus error, arbitration lost or acknowledge failure is set. Otherwise `irq_err` is low.
- R8: A write to status register 1 clears each error flag whose bit is written 0 and leaves it unchanged where the bit is written 1. Such a write does not change the event flags.
- R9: Address-sent clears on a read of status register 2 only when a read of status register 1 saw it set earlier. A new address-sent pulse cancels that pending read.
- R10: Start-sent clears on a data register write only when a read of status register 1 saw it set earlier. Reads of the data register do not cancel the pending clear.
- R11: A data register read clears receive-not-empty. A data register write clears transmit-empty. Either access clears byte-finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_start | input | 1 | Pulse: START condition was sent |
| set_addr | input | 1 | Pulse: address byte was sent |
| set_btf | input | 1 | Pulse: byte transfer finished |
| set_rxne | input | 1 | Pulse: receive holding register filled |
| set_txe | input | 1 | Pulse: transmit holding register emptied |
| set_berr | input | 1 | Pulse: bus error |
| set_arlo | input | 1 | Pulse: arbitration lost |
| set_nack | input | 1 | Pulse: acknowledge failure |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 status 1, 2 status 2, 3 data) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| irq_evt | output | 1 | Event interrupt, level |
| irq_err | output | 1 | Error interrupt, level |

## Verification
A set pulse from the byte engine can arrive in the same cycle as the register access that clears the same flag. This happens for a zero written to an error bit, for the status 2 read that ends the address-sent sequence, and for a data read that takes the received byte. The bench drives the pulse and the clearing access in one vector. It then judges the result at the ports: the interrupt line must stay high, and a later read of status register 1 must still show the flag. For address-sent, the bench also checks that one more status 2 read leaves the flag set, because the pulse cancelled the pending clear.

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter int FREQ_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_start,
  input  logic              set_addr,
  input  logic              set_btf,
  input  logic              set_rxne,
  input  logic              set_txe,
  input  logic              set_berr,
  input  logic              set_arlo,
  input  logic              set_nack,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_evt,
  output logic              irq_err
);

  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ST1  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_ST2  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_DAT  = SEL_W'(3);

  localparam int B_ERREN = 8;
  localparam int B_EVTEN = 9;
  localparam int B_BUFEN = 10;

  localparam int B_SB   = 0;
  localparam int B_ADDR = 1;
  localparam int B_BTF  = 2;
  localparam int B_RXNE = 6;
  localparam int B_TXE  = 7;
  localparam int N_ERR  = 3;
  localparam int B_ERR0 = 8;

  logic              rd_st1, rd_st2, rd_dat, wr_ctl, wr_st1, wr_dat;
  logic [FREQ_W-1:0] freq_q;
  logic              erren_q, evten_q, bufen_q;
  logic              sb_q, sb_arm_q, addr_q, addr_arm_q, btf_q, rxne_q, txe_q;
  logic [N_ERR-1:0]  err_q;
  logic [N_ERR-1:0]  err_set;
  logic [DATA_W-1:0] ctrl_view, sr1_view;

  assign rd_st1 = reg_rd && reg_sel == SEL_ST1;
  assign rd_st2 = reg_rd && reg_sel == SEL_ST2;
  assign rd_dat = reg_rd && reg_sel == SEL_DAT;
  assign wr_ctl = reg_wr && reg_sel == SEL_CTRL;
  assign wr_st1 = reg_wr && reg_sel == SEL_ST1;
  assign wr_dat = reg_wr && reg_sel == SEL_DAT;

  assign err_set = {set_nack, set_arlo, set_berr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= '0;
      erren_q <= 1'b0;
      evten_q <= 1'b0;
      bufen_q <= 1'b0;
    end else if (wr_ctl) begin
      freq_q  <= wr_data[FREQ_W-1:0];
      erren_q <= wr_data[B_ERREN];
      evten_q <= wr_data[B_EVTEN];
      bufen_q <= wr_data[B_BUFEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q     <= 1'b0;
      sb_arm_q <= 1'b0;
    end else if (set_start) begin
      sb_q     <= 1'b1;
      sb_arm_q <= 1'b0;
    end else if (sb_arm_q && wr_dat) begin
      sb_q     <= 1'b0;
      sb_arm_q <= 1'b0;
    end else if (rd_st1 && sb_q) begin
      sb_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= 1'b0;
      addr_arm_q <= 1'b0;
    end else if (set_addr) begin
      addr_q     <= 1'b1;
      addr_arm_q <= 1'b0;
    end else if (addr_arm_q && rd_st2) begin
      addr_q     <= 1'b0;
      addr_arm_q <= 1'b0;
    end else if (rd_st1 && addr_q) begin
      addr_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btf_q  <= 1'b0;
      rxne_q <= 1'b0;
      txe_q  <= 1'b0;
    end else begin
      if (set_btf)                btf_q  <= 1'b1;
      else if (rd_dat || wr_dat)  btf_q  <= 1'b0;
      if (set_rxne)               rxne_q <= 1'b1;
      else if (rd_dat)            rxne_q <= 1'b0;
      if (set_txe)                txe_q  <= 1'b1;
      else if (wr_dat)            txe_q  <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             err_q[i] <= 1'b0;
      else if (err_set[i])                    err_q[i] <= 1'b1;
      else if (wr_st1 && !wr_data[B_ERR0+i])  err_q[i] <= 1'b0;
    end
  end

  always_comb begin
    ctrl_view                         = '0;
    ctrl_view[FREQ_W-1:0]             = freq_q;
    ctrl_view[B_ERREN]                = erren_q;
    ctrl_view[B_EVTEN]                = evten_q;
    ctrl_view[B_BUFEN]                = bufen_q;
    sr1_view                          = '0;
    sr1_view[B_SB]                    = sb_q;
    sr1_view[B_ADDR]                  = addr_q;
    sr1_view[B_BTF]                   = btf_q;
    sr1_view[B_RXNE]                  = rxne_q;
    sr1_view[B_TXE]                   = txe_q;
    sr1_view[B_ERR0+N_ERR-1:B_ERR0]   = err_q;
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: rd_data = ctrl_view;
      SEL_ST1:  rd_data = sr1_view;
      default:  rd_data = '0;
    endcase
  end

  assign irq_evt = evten_q && (sb_q || addr_q || btf_q || (bufen_q && (rxne_q || txe_q)));
  assign irq_err = erren_q && (|err_q);

endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              set_addr,
  input logic              irq_evt,
  input logic              irq_err,
  input logic [DATA_W-1:0] sr1,
  input logic [DATA_W-1:0] ctrl
);

  AST_SET_REACHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_addr |=> sr1[1]); // R4

  AST_EVT_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[9] && sr1[0]) |-> irq_evt); // R5

  AST_BUF_NEEDS_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && sr1[2:0] == 3'b000) |-> (ctrl[9] && ctrl[10])); // R6

  AST_ERR_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[8] |-> !irq_err); // R7

  AST_ONE_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_W'(1) && wr_data[9] && sr1[9]) |=> sr1[9]); // R8

  AST_ADDR_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr1[1]) |-> $past(reg_rd && reg_sel == SEL_W'(2))); // R9

  AST_RXNE_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr1[6]) |-> $past(reg_rd && reg_sel == SEL_W'(3))); // R11

endmodule

bind i2c_irq_status i2c_irq_status_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .wr_data  (wr_data),
  .set_addr (set_addr),
  .irq_evt  (irq_evt),
  .irq_err  (irq_err),
  .sr1      (sr1_view),
  .ctrl     (ctrl_view)
);

// File: tb/i2c_irq_status_tb_top.sv
module i2c_irq_status_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_STEPS    = 47;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sel;
    logic [15:0] wd;
    logic [7:0]  set;
    logic [15:0] erd;
    logic        ev;
    logic        er;
    logic [3:0]  req;
  } step_t;

  // op: 0 idle, 1 read, 2 write. set bits: 0 start, 1 addr, 2 btf, 3 rxne, 4 txe, 5 berr, 6 arlo, 7 nack
  localparam step_t STEPS [N_STEPS] = '{
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd1},  // R1 reset status
    '{2'd0, 2'd0, 16'h0000, 8'h01, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 masked
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0001, 1'b0, 1'b0, 4'd3},  // R3 bit 0
    '{2'd2, 2'd0, 16'h0208, 8'h00, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5 enable
    '{2'd1, 2'd0, 16'h0000, 8'h00, 16'h0208, 1'b1, 1'b0, 4'd2},  // R2 readback
    '{2'd2, 2'd3, 16'h0055, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd10}, // R10 clear
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd10}, // R10
    '{2'd0, 2'd0, 16'h0000, 8'h10, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 no buf en
    '{2'd2, 2'd0, 16'h0608, 8'h00, 16'h0000, 1'b1, 1'b0, 4'd6},  // R6 buf en
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0080, 1'b1, 1'b0, 4'd3},  // R3 bit 7
    '{2'd2, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11 txe
    '{2'd0, 2'd0, 16'h0000, 8'h02, 16'h0000, 1'b1, 1'b0, 4'd4},  // R4
    '{2'd1, 2'd2, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 4'd9},  // R9 no prior read
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0002, 1'b1, 1'b0, 4'd9},  // R9 arm
    '{2'd1, 2'd2, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 clear
    '{2'd0, 2'd0, 16'h0000, 8'h08, 16'h0000, 1'b1, 1'b0, 4'd6},  // R6 rxne
    '{2'd1, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11 rxne
    '{2'd0, 2'd0, 16'h0000, 8'h04, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5 btf
    '{2'd2, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11 btf
    '{2'd0, 2'd0, 16'h0000, 8'h60, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 masked
    '{2'd2, 2'd0, 16'h0708, 8'h00, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 enable
    '{2'd2, 2'd1, 16'hFEFF, 8'h00, 16'h0000, 1'b0, 1'b1, 4'd8},  // R8 clear berr
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0200, 1'b0, 1'b1, 4'd8},  // R8 arlo kept
    '{2'd2, 2'd1, 16'hFDFF, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 clear arlo
    '{2'd0, 2'd0, 16'h0000, 8'h80, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 nack
    '{2'd2, 2'd1, 16'h0000, 8'h80, 16'h0000, 1'b0, 1'b1, 4'd4},  // R4 set beats clear
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0400, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd2, 2'd1, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8
    '{2'd0, 2'd0, 16'h0000, 8'h02, 16'h0000, 1'b1, 1'b0, 4'd4},  // R4
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0002, 1'b1, 1'b0, 4'd9},  // R9 arm
    '{2'd1, 2'd2, 16'h0000, 8'h02, 16'h0000, 1'b1, 1'b0, 4'd9},  // R9 set beats clear
    '{2'd1, 2'd2, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 4'd9},  // R9 arm cancelled
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0002, 1'b1, 1'b0, 4'd9},  // R9
    '{2'd1, 2'd2, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9
    '{2'd1, 2'd3, 16'h0000, 8'h08, 16'h0000, 1'b1, 1'b0, 4'd4},  // R4 rxne vs read
    '{2'd1, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11
    '{2'd2, 2'd0, 16'h0308, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6
    '{2'd0, 2'd0, 16'h0000, 8'h10, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 masked
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0080, 1'b0, 1'b0, 4'd6},  // R6 flag held
    '{2'd2, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11
    '{2'd2, 2'd0, 16'hFFFF, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2
    '{2'd1, 2'd0, 16'h0000, 8'h00, 16'h073F, 1'b0, 1'b0, 4'd2},  // R2 unused bits
    '{2'd0, 2'd0, 16'h0000, 8'h01, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5
    '{2'd2, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 4'd10}, // R10 not armed
    '{2'd1, 2'd1, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0, 4'd10}, // R10 arm
    '{2'd1, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 4'd10}, // R10 read keeps arm
    '{2'd2, 2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 4'd10}  // R10 clear
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  set_v = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_evt, irq_err;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_start (set_v[0]),
    .set_addr  (set_v[1]),
    .set_btf   (set_v[2]),
    .set_rxne  (set_v[3]),
    .set_txe   (set_v[4]),
    .set_berr  (set_v[5]),
    .set_arlo  (set_v[6]),
    .set_nack  (set_v[7]),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq_evt   (irq_evt),
    .irq_err   (irq_err)
  );

  task automatic check(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_v = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_sel = '0; wr_data = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hang, expected completion");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset evt line", 1, {15'd0, irq_evt}, 16'h0); // R1
    check("reset err line", 1, {15'd0, irq_err}, 16'h0); // R1
    check("reset ctrl", 1, rd_data, 16'h0);              // R1
    rst_n = 1'b1;

    for (int i = 0; i < N_STEPS; i++) begin
      @(negedge clk);
      set_v   = STEPS[i].set;
      reg_rd  = STEPS[i].op == 2'd1;
      reg_wr  = STEPS[i].op == 2'd2;
      reg_sel = STEPS[i].sel;
      wr_data = STEPS[i].wd;
      #1;
      if (STEPS[i].op == 2'd1)
        check($sformatf("step %0d read", i), int'(STEPS[i].req), rd_data, STEPS[i].erd);
      @(posedge clk);
      #1;
      check($sformatf("step %0d evt line", i), int'(STEPS[i].req), {15'd0, irq_evt}, {15'd0, STEPS[i].ev});
      check($sformatf("step %0d err line", i), int'(STEPS[i].req), {15'd0, irq_err}, {15'd0, STEPS[i].er});
    end

    // R1: reset in mid-run with flags and enables set
    @(negedge clk);
    idle_inputs();
    set_v = 8'h95;
    @(negedge clk);
    idle_inputs();
    reg_sel = 2'd0; wr_data = 16'h0715; reg_wr = 1'b1;
    @(negedge clk);
    idle_inputs();
    #1;
    check("flags before reset", 1, {15'd0, irq_evt & irq_err}, 16'h1); // R1
    rst_n = 1'b0;
    #1;
    check("evt after async reset", 1, {15'd0, irq_evt}, 16'h0); // R1
    @(negedge clk);
    rst_n = 1'b1;
    reg_sel = 2'd1;
    #1;
    check("status after reset", 1, rd_data, 16'h0); // R1
    reg_sel = 2'd0;
    #1;
    check("ctrl after reset", 1, rd_data, 16'h0);   // R1

    // R3: status 2 and data selects read zero even with flags set
    @(negedge clk);
    set_v = 8'hFF;
    @(negedge clk);
    idle_inputs();
    reg_sel = 2'd2;
    #1;
    check("status 2 reads zero", 3, rd_data, 16'h0); // R3
    reg_sel = 2'd3;
    #1;
    check("data reads zero", 3, rd_data, 16'h0);     // R3
    reg_sel = 2'd1;
    #1;
    check("all flags layout", 3, rd_data, 16'h07C7); // R3

    done = 1'b1;
    finish_run();
  end

endmodule